// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a small single-port synchronous memory with a burst front end, meant to stand in for an external burst SRAM inside a larger design or a system bench. Every control and data input is taken at the rising clock edge. An access starts on either of two start strobes, one meant for a processor and one for a memory controller. After the start, a two-bit internal counter produces the following addresses of the burst each time the advance input is low. The counter runs in linear or interleaved order, selected by an input. The burst counter need not be used at all, because a fresh address can be started on every cycle.

A static mode input chooses how read data leaves the array. In flow-through mode the array output goes straight to the pins. In pipeline mode it passes through one more output register. Writes either cover the whole word or only selected 9-bit byte lanes. Output enable and sleep act on the output drive immediately, without waiting for the clock. While sleep is high the clock edges perform no access and the stored contents stay intact.

Top module: `burst_sram`

## Requirements
- R1: The chip counts as selected only when ce1N=0, ce2=1 and ce3N=0 at an edge where a start strobe is low. A start with any other combination performs no read and no write, and it ends any running burst.
- R2: A start on startCtrlN alone writes when a write request is present, and otherwise reads. A write request is globalWrN=0, or byteWrEnN=0 together with at least one byteSelN bit at 0. During a burst the same rule applies at each later cycle.
- R3: With globalWrN=0, all four lanes of the word are written, whatever byteWrEnN and byteSelN are.
- R4: With globalWrN=1 and byteWrEnN=0, only lane i with byteSelN[i]=0 is written. Lane i is data bits 9i+8 down to 9i. With byteWrEnN=1 and globalWrN=1, nothing is written.
- R5: A start on startProcN is always a read, even with write controls asserted. It also wins when both start strobes are low.
- R6: In flow-through mode (pipeMode=0), the word read at edge k is driven on dataOut right after edge k.
- R7: In pipeline mode (pipeMode=1), the word read at edge k appears only after edge k+1. After a start that follows an idle cycle, nothing is driven between edges k and k+1.
- R8: Each cycle of a burst with advN=0 steps a 2-bit counter n. The upper address bits stay fixed. The low two bits equal the start's low bits plus n modulo 4 when linearOrder=1, and the start's low bits XOR n when linearOrder=0.
- R9: With advN=1 during a burst, the access repeats at the same address. With no burst running, for example after reset or after a deselect, advN=0 causes no access and dataDrive stays 0.
- R10: After a deselecting start, dataDrive goes low at once in flow-through mode. In pipeline mode it stays high for one more cycle with the last read word, then goes low.
- R11: outEnN=1 forces dataDrive low immediately without a clock edge. Returning outEnN to 0 restores the drive.
- R12: sleep=1 forces dataDrive low immediately. Edges during sleep perform no access, and stored contents and access state are kept.
- R13: dataDrive is low in the cycle after an edge that performed a write, in both output modes.
- R14: Starts on consecutive edges, each with a new address, each return the word of their own address in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset of the access state (not the array) |
| pipeMode | input | 1 | 1: registered read path, 0: flow-through |
| linearOrder | input | 1 | 1: linear burst order, 0: interleaved |
| addr | input | ADDR_W | Word address taken at a start |
| dataIn | input | LANES*LANE_W | Write data |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| startProcN | input | 1 | Processor start strobe, active low, read only |
| startCtrlN | input | 1 | Controller start strobe, active low |
| advN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Whole-word write, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| byteSelN | input | LANES | Per-lane write selects, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| dataOut | output | LANES*LANE_W | Read data, zero when not driven |
| dataDrive | output | 1 | High when dataOut is actively driven |

## Verification
The bench builds the block with its defaults: 6 address bits, giving 64 words, four lanes of 9 bits and a 2-bit burst counter. At this size the bench keeps a full copy of the array. It writes and reads back every address in both output modes, with back-to-back starts. It applies all 16 lane-select patterns to one word and all eight chip-enable combinations. It runs bursts from each of the four low-bit starting offsets in both orders and both modes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Strobes from the access control to the datapath for one edge
  typedef struct packed {
    logic doRead;
    logic doWrite;
  } memStrobe_t;

  // What the current edge does to the access state
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_START = 2'd1,
    CYC_DESEL = 2'd2,
    CYC_CONT  = 2'd3
  } cycleKind_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              pipeMode,
  input  logic              linearOrder,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              startProcN,
  input  logic              startCtrlN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  byteSelN,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  laneMask,
  output logic              outValid,
  output logic              wrLast
);

  localparam int HIGH_W = ADDR_W - BURST_W;

  logic selected, procSt, ctrlSt, wrReq, isWr;
  cycleKind_t kind;
  logic [ADDR_W-1:0]  baseQ;
  logic [BURST_W-1:0] cntQ, cntNext, burstLow;
  logic activeQ, rdValidQ, pipeValidQ, wrLastQ;

  always_comb begin
    selected = !ce1N && ce2 && !ce3N;
    procSt   = !startProcN;
    ctrlSt   = !startCtrlN;
    wrReq    = !globalWrN || (!byteWrEnN && (|(~byteSelN)));
    laneMask = !globalWrN ? {LANES{1'b1}} : ~byteSelN;

    if (sleep)                         kind = CYC_IDLE;
    else if ((procSt || ctrlSt) && selected) kind = CYC_START;
    else if (procSt || ctrlSt)         kind = CYC_DESEL;
    else if (activeQ)                  kind = CYC_CONT;
    else                               kind = CYC_IDLE;

    cntNext  = !advN ? cntQ + 1'b1 : cntQ;
    burstLow = linearOrder ? (baseQ[BURST_W-1:0] + cntNext)
                           : (baseQ[BURST_W-1:0] ^ cntNext);

    if (kind == CYC_START) memAddr = addr;
    else                   memAddr = {baseQ[ADDR_W-1 -: HIGH_W], burstLow};

    case (kind)
      CYC_START: isWr = !procSt && wrReq;
      CYC_CONT:  isWr = wrReq;
      default:   isWr = 1'b0;
    endcase

    strobe.doWrite = isWr;
    strobe.doRead  = ((kind == CYC_START) || (kind == CYC_CONT)) && !isWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ      <= '0;
      cntQ       <= '0;
      activeQ    <= 1'b0;
      rdValidQ   <= 1'b0;
      pipeValidQ <= 1'b0;
      wrLastQ    <= 1'b0;
    end else if (!sleep) begin
      case (kind)
        CYC_START: begin
          baseQ   <= addr;
          cntQ    <= '0;
          activeQ <= 1'b1;
        end
        CYC_DESEL: activeQ <= 1'b0;
        CYC_CONT:  cntQ    <= cntNext;
        default:   ;
      endcase
      rdValidQ   <= strobe.doRead;
      pipeValidQ <= rdValidQ;
      wrLastQ    <= strobe.doWrite;
    end
  end

  assign outValid = pipeMode ? pipeValidQ : rdValidQ;
  assign wrLast   = wrLastQ;

endmodule

// File: rtl/burst_data.sv
module burst_data
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  memStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    pipeMode,
  input  logic                    outValid,
  input  logic                    wrLast,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] curWord, wrWord, flowData, pipeDataQ;
  logic [ADDR_W-1:0] rdAddrQ;

  assign curWord = mem[memAddr];

  // Merge the selected lanes into the stored word
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign wrWord[g*LANE_W +: LANE_W] = laneMask[g] ? dataIn[g*LANE_W +: LANE_W]
                                                    : curWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (strobe.doWrite) mem[memAddr] <= wrWord;
    if (strobe.doRead)  rdAddrQ <= memAddr;
    if (!sleep)         pipeDataQ <= flowData;
  end

  assign flowData  = mem[rdAddrQ];
  assign dataDrive = outValid && !wrLast && !outEnN && !sleep;
  assign dataOut   = dataDrive ? (pipeMode ? pipeDataQ : flowData) : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pipeMode,
  input  logic                    linearOrder,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    startProcN,
  input  logic                    startCtrlN,
  input  logic                    advN,
  input  logic                    globalWrN,
  input  logic                    byteWrEnN,
  input  logic [LANES-1:0]        byteSelN,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);

  memStrobe_t        strobe;
  logic [ADDR_W-1:0] memAddr;
  logic [LANES-1:0]  laneMask;
  logic              outValid, wrLast;

  burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep), .pipeMode(pipeMode),
    .linearOrder(linearOrder), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .startProcN(startProcN), .startCtrlN(startCtrlN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteSelN(byteSelN),
    .strobe(strobe), .memAddr(memAddr), .laneMask(laneMask),
    .outValid(outValid), .wrLast(wrLast)
  );

  burst_data #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_data (
    .clk(clk), .strobe(strobe), .memAddr(memAddr), .laneMask(laneMask),
    .dataIn(dataIn), .pipeMode(pipeMode), .outValid(outValid), .wrLast(wrLast),
    .outEnN(outEnN), .sleep(sleep), .dataOut(dataOut), .dataDrive(dataDrive)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import burst_sram_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sleep,
  input logic       outEnN,
  input logic       pipeMode,
  input logic       ce1N,
  input logic       ce2,
  input logic       ce3N,
  input logic       startProcN,
  input logic       startCtrlN,
  input logic       dataDrive,
  input memStrobe_t strobe
);

  logic chipSel, anyStart;
  assign chipSel  = !ce1N && ce2 && !ce3N;
  assign anyStart = !startProcN || !startCtrlN;

  a_r1_desel_noop: assert property (@(posedge clk) disable iff (!rstN)
    (anyStart && !chipSel) |-> (!strobe.doRead && !strobe.doWrite));

  a_r5_proc_read: assert property (@(posedge clk) disable iff (!rstN)
    (!startProcN && chipSel) |-> !strobe.doWrite);

  a_r10_flow_desel: assert property (@(posedge clk) disable iff (!rstN)
    (anyStart && !chipSel && !sleep) |=> (pipeMode || !dataDrive));

  a_r11_oe_hiz: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  a_r12_sleep_hiz: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataDrive);

  a_r12_sleep_noop: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (!strobe.doRead && !strobe.doWrite));

  a_r13_write_hiz: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrite |=> !dataDrive);

endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .outEnN(outEnN), .pipeMode(pipeMode),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .startProcN(startProcN),
  .startCtrlN(startCtrlN), .dataDrive(dataDrive), .strobe(strobe)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;

  logic        clk = 1'b0;
  logic        rstN, pipeMode, linearOrder;
  logic [5:0]  addr;
  logic [35:0] dataIn;
  logic        ce1N, ce2, ce3N, startProcN, startCtrlN, advN;
  logic        globalWrN, byteWrEnN, outEnN, sleep;
  logic [3:0]  byteSelN;
  logic [35:0] dataOut;
  logic        dataDrive;

  logic [35:0] model [64];
  int nTests = 0;
  int nFail  = 0;

  burst_sram u0 (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .linearOrder(linearOrder),
    .addr(addr), .dataIn(dataIn), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .startProcN(startProcN), .startCtrlN(startCtrlN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteSelN(byteSelN),
    .outEnN(outEnN), .sleep(sleep), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  always #2 clk = ~clk;

  function automatic logic [35:0] pat(input int v);
    return (36'(v) * 36'h09E3779B) ^ 36'h5A5A5A5A5;
  endfunction

  function automatic logic [5:0] bAddr(input logic [5:0] s, input int n, input bit lin);
    logic [1:0] low;
    low = lin ? 2'(s[1:0] + 2'(n)) : (s[1:0] ^ 2'(n));
    return {s[5:2], low};
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setIdle();
    startProcN = 1; startCtrlN = 1; advN = 1; globalWrN = 1; byteWrEnN = 1;
    byteSelN = 4'hF; ce1N = 0; ce2 = 1; ce3N = 0; dataIn = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic desel();
    setIdle(); ce1N = 1; startCtrlN = 0; tick(); setIdle();
  endtask

  task automatic rdStart(input logic [5:0] a);
    setIdle(); addr = a; startProcN = 0; tick(); setIdle();
  endtask

  task automatic wrGlobal(input logic [5:0] a, input logic [35:0] d);
    setIdle(); addr = a; dataIn = d; startCtrlN = 0; globalWrN = 0; tick(); setIdle();
    model[a] = d;
  endtask

  task automatic flowRead(input logic [5:0] a, input string tag);
    rdStart(a);
    chk(tag, dataOut, model[a]);
    chk(tag, 36'(dataDrive), 36'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nTests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 0; pipeMode = 0; linearOrder = 1; outEnN = 0; sleep = 0; addr = '0;
    setIdle();
    repeat (3) tick();
    chk("R9 reset drive", 36'(dataDrive), 36'd0);
    rstN = 1; tick();
    advN = 0; tick(); setIdle();
    chk("R9 advance without burst", 36'(dataDrive), 36'd0);

    // Fill every word
    for (int a = 0; a < 64; a++) wrGlobal(6'(a), pat(a));
    chk("R13 drive after write", 36'(dataDrive), 36'd0);
    desel();

    // Flow-through, new address each cycle
    for (int a = 0; a < 64; a++) flowRead(6'(a), "R6 R14 flow sweep");
    desel();
    chk("R10 flow deselect", 36'(dataDrive), 36'd0);

    // Pipeline, new address each cycle
    pipeMode = 1; desel(); tick();
    for (int a = 0; a < 64; a++) begin
      rdStart(6'(a));
      if (a == 0) chk("R7 no data after first edge", 36'(dataDrive), 36'd0);
      else        chk("R7 R14 pipe sweep", dataOut, model[a-1]);
    end
    desel();
    chk("R10 pipe deselect hold drive", 36'(dataDrive), 36'd1);
    chk("R10 pipe deselect hold data", dataOut, model[63]);
    tick();
    chk("R10 pipe deselect off", 36'(dataDrive), 36'd0);

    // Write after read turns drive off
    rdStart(5);
    wrGlobal(6, pat(600));
    chk("R13 pipe write hiz", 36'(dataDrive), 36'd0);
    desel(); pipeMode = 0;
    flowRead(6, "R13 pipe written word");
    rdStart(7);
    wrGlobal(8, pat(800));
    chk("R13 flow write hiz", 36'(dataDrive), 36'd0);
    desel();
    flowRead(8, "R13 flow written word");

    // Bursts: both orders, both modes, every low offset
    for (int lin = 0; lin < 2; lin++)
      for (int mode = 0; mode < 2; mode++)
        for (int low = 0; low < 4; low++) begin
          logic [5:0] s;
          s = 6'(lin * 32 + mode * 16 + low * 5);
          desel();
          linearOrder = lin[0]; pipeMode = mode[0];
          rdStart(s);
          for (int n = 0; n < 4; n++) begin
            if (mode == 1) begin advN = (n < 3) ? 1'b0 : 1'b1; tick(); advN = 1; end
            chk("R8 burst beat", dataOut, model[bAddr(s, n, lin[0])]);
            if (mode == 0 && n < 3) begin advN = 0; tick(); advN = 1; end
          end
        end
    desel(); pipeMode = 0;

    // Suspend in interleaved order
    linearOrder = 0;
    rdStart(22);
    advN = 0; tick(); advN = 1;
    chk("R8 interleaved beat1", dataOut, model[23]);
    tick();
    chk("R9 suspend repeats", dataOut, model[23]);
    advN = 0; tick(); advN = 1;
    chk("R8 interleaved beat2", dataOut, model[20]);
    desel(); linearOrder = 1;

    // Burst write from the controller strobe
    wrGlobal(44, pat(440));
    globalWrN = 0; advN = 0; dataIn = pat(450); tick(); setIdle();
    model[45] = pat(450);
    desel();
    flowRead(44, "R2 burst write first");
    flowRead(45, "R2 burst write second");
    desel();

    // Byte lanes, every select pattern
    for (int m = 0; m < 16; m++) begin
      logic [35:0] d;
      d = pat(m + 100);
      setIdle(); addr = 40; startCtrlN = 0; byteWrEnN = 0;
      byteSelN = ~4'(m); dataIn = d; tick(); setIdle();
      for (int g = 0; g < 4; g++)
        if (m[g]) model[40][g*9 +: 9] = d[g*9 +: 9];
      desel();
      flowRead(40, "R4 lane select");
    end
    setIdle(); addr = 40; startCtrlN = 0; byteSelN = 4'h0; dataIn = pat(7); tick(); setIdle();
    desel();
    flowRead(40, "R4 byte enable off no write");

    // Global write overrides byte controls
    setIdle(); addr = 41; startCtrlN = 0; globalWrN = 0; dataIn = pat(410); tick(); setIdle();
    model[41] = pat(410);
    desel(); flowRead(41, "R3 global with byte enable off");
    setIdle(); addr = 42; startCtrlN = 0; globalWrN = 0; byteWrEnN = 0; byteSelN = 4'b1110;
    dataIn = pat(420); tick(); setIdle();
    model[42] = pat(420);
    desel(); flowRead(42, "R3 global over byte selects");
    chk("R2 controller write stored", model[42], pat(420));

    // Processor start is a read and wins
    desel();
    setIdle(); addr = 50; startProcN = 0; globalWrN = 0; dataIn = ~model[50]; tick(); setIdle();
    chk("R5 proc start reads", dataOut, model[50]);
    setIdle(); addr = 50; startProcN = 0; startCtrlN = 0; globalWrN = 0; dataIn = ~model[50];
    tick(); setIdle();
    chk("R5 both strobes read", dataOut, model[50]);
    desel(); flowRead(50, "R5 word unchanged");

    // Chip enable combinations
    for (int c = 0; c < 8; c++) begin
      if (c == 2) continue;
      rdStart(9);
      setIdle(); ce1N = c[0]; ce2 = c[1]; ce3N = c[2];
      startCtrlN = 0; globalWrN = 0; addr = 10; dataIn = ~model[10]; tick(); setIdle();
      chk("R1 unselected start no access", 36'(dataDrive), 36'd0);
    end
    desel(); flowRead(10, "R1 no write when unselected");

    // Output enable is asynchronous
    rdStart(12);
    outEnN = 1; #1;
    chk("R11 oe off", 36'(dataDrive), 36'd0);
    outEnN = 0; #1;
    chk("R11 oe back", dataOut, model[12]);
    desel();

    // Sleep
    rdStart(13);
    sleep = 1; #1;
    chk("R12 sleep hiz", 36'(dataDrive), 36'd0);
    setIdle(); addr = 13; startCtrlN = 0; globalWrN = 0; dataIn = ~model[13]; tick(); setIdle();
    sleep = 0; #1;
    chk("R12 state kept", dataOut, model[13]);
    desel(); flowRead(13, "R12 contents kept");
    desel();

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule